// File: doc/BRIEF.md
# Three-Wire Serial Register Write Port

This block receives register writes over a three-line serial link made of a serial clock, a data line and a latch/select line. All three lines are sampled in the system clock domain. Each rising edge of the serial clock pushes one data bit into a 16-bit shift register. The register shifts freely and has no bit counter, so only the most recent 16 bits are kept.

When the latch line rises, the block takes the current shift-register contents as a control word. The upper 7 bits of the word are the register address and the lower 9 bits are the register value. The block then presents these on its write port together with a single-cycle write enable, and a register file on the same chip consumes the write.

The port is active only while the mode strap input is high. While the strap is low, serial activity has no effect.

Top module: `ctl3w_rx`

## Requirements
- R1: While rst_ni is low, and after it is released, wr_en_o is 0 and wr_addr_o and wr_data_o are 0.
- R2: Bits are taken on serial clock rising edges, and the first bit received becomes word bit 15. wr_addr_o is word bits 15..9 and wr_data_o is word bits 8..0.
- R3: If more than 16 bits precede a latch edge, only the last 16 bits form the word. The earlier bits are dropped.
- R4: Each rising edge of the latch line produces exactly one wr_en_o pulse, and that pulse lasts exactly one system clock cycle.
- R5: Serial clock edges and falling edges of the latch line never raise wr_en_o.
- R6: While mode_i is low, latch edges produce no write and serial clock edges do not change the shift register. Bits shifted earlier are still present after mode_i returns high.
- R7: If fewer than 16 new bits precede a latch edge, the word is the previous contents shifted left by the number of new bits, with the new bits in the low positions.
- R8: wr_addr_o and wr_data_o change only in the cycle in which wr_en_o is high, and they hold their value between write pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode strap; high enables the three-wire port |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| sel_i | input | 1 | Latch/select line; a rising edge commits the word |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Register address of the write |
| wr_data_o | output | 9 | Register value of the write |

## Verification
A shift register that is off by one position shows up at the next write strobe as a word that is misaligned, rotated or has its fields swapped. The address and data then disagree with the bits that were sent, and this is visible about four system cycles after the latch edge. A fault in edge detection shows up at the write port as missing, doubled or stretched strobes, or as strobes caused by serial clock activity. The mode gate is checked in two steps: first no strobe may appear while the strap is low, and then a later latch must show that the shift contents were left untouched.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned WORD_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctl_word_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl3w_edge.sv
module ctl3w_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic              latch_i,
  output logic              wr_en_o,
  output ctl_word_t         word_o
);
  logic [WORD_W-1:0] sr_q;
  ctl_word_t         word_q;
  logic              wr_en_q;

  // no bit counter: older bits fall off the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sr_q <= '0;
    else if (en_i && bit_stb_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q <= 1'b0;
      word_q  <= '0;
    end else begin
      wr_en_q <= en_i && latch_i;
      if (en_i && latch_i) word_q <= sr_q;
    end
  end

  assign wr_en_o = wr_en_q;
  assign word_o  = word_q;

  // R6
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wr_en_q);
  // R6
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sr_q));
  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_q |-> $stable(word_q));
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sel_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned NLINES = 4;
  localparam int unsigned NEDGE  = 2;

  logic [NLINES-1:0] raw, syn;
  logic [NEDGE-1:0]  rise, fall;
  ctl_word_t         word;

  assign raw = {mode_i, sel_i, sdat_i, sclk_i};

  ctl3w_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  // bit 0: serial clock, bit 1: select
  ctl3w_edge #(.W(NEDGE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({syn[2], syn[0]}),
    .rise_o (rise),
    .fall_o (fall)
  );

  ctl3w_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (syn[3]),
    .bit_stb_i (rise[0]),
    .bit_i     (syn[1]),
    .latch_i   (rise[1]),
    .wr_en_o   (wr_en_o),
    .word_o    (word)
  );

  assign wr_addr_o = word.addr;
  assign wr_data_o = word.data;

  // R5
  wr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rise[1]));
  // R4
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R5
  no_fall_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall[1] |=> !wr_en_o);
endmodule

// File: tb/ctl3w_rx_tb.sv
module ctl3w_rx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode = 1'b1, sclk = 1'b0, sdat = 1'b0, sel = 1'b0;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_wide = 0;
  logic       prev_en = 1'b0;
  logic [15:0] last_word = '0;

  always #10 clk = ~clk;

  ctl3w_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .sclk_i(sclk), .sdat_i(sdat), .sel_i(sel),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (wr_en) begin
        n_wr++;
        last_word = {wr_addr, wr_data};
        if (prev_en) n_wide++;
      end
      prev_en = wr_en;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(logic b);
    sdat = b; wclk(4);
    sclk = 1'b1; wclk(4);
    sclk = 1'b0; wclk(4);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic latch();
    sel = 1'b1; wclk(8);
    sel = 1'b0; wclk(8);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 en", wr_en, 0);
    chk("R1 addr", wr_addr, 0);
    chk("R1 data", wr_data, 0);
  endtask

  task automatic t_basic(logic [15:0] w);
    int c0 = n_wr;
    send_bits(w, 16);
    chk("R5 no wr from sclk", n_wr - c0, 0);
    latch();
    chk("R4 one pulse", n_wr - c0, 1);
    chk("R2 word", last_word, w);
    @(negedge clk);
    chk("R2 addr", wr_addr, w[15:9]);
    chk("R2 data", wr_data, w[8:0]);
  endtask

  task automatic t_overrun();
    send_bits(32'h0000_0155, 9);
    send_bits(32'h0000_9C3A, 16);
    latch();
    chk("R3 last 16 bits", last_word, 16'h9C3A);
  endtask

  task automatic t_short();
    logic [15:0] prev = last_word;
    send_bits(32'h5, 4);
    latch();
    chk("R7 partial", last_word, {prev[11:0], 4'h5});
  endtask

  task automatic t_mode();
    int c0;
    send_bits(32'h0000_3E81, 16);
    mode = 1'b0; wclk(6);
    c0 = n_wr;
    send_bits(32'h0000_FFFF, 16);
    latch();
    chk("R6 no wr when mode low", n_wr - c0, 0);
    mode = 1'b1; wclk(6);
    latch();
    chk("R6 shift kept", last_word, 16'h3E81);
    chk("R6 one wr after mode high", n_wr - c0, 1);
  endtask

  task automatic t_hold();
    logic [15:0] w = last_word;
    send_bits(32'h0000_1234, 10);
    sel = 1'b1; wclk(1);
    sel = 1'b0; wclk(1);
    sel = 1'b0; wclk(10);
    @(negedge clk);
    chk("R8 hold", {wr_addr, wr_data}, {w[5:0], 10'h234});
  endtask

  initial begin
    fork
      begin : wd
        #5ms;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    join_none
    wclk(3);
    t_reset();
    rst_ni = 1'b1; wclk(4);
    t_reset();
    t_basic(16'hA5C3);
    t_basic(16'h0001);
    t_basic(16'hFE00);
    t_overrun();
    t_short();
    t_mode();
    t_hold();
    chk("R4 pulse width", n_wide, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule